// File: doc/BRIEF.md
# Floating-Point Register Stack Tag and Pointer Controller

This block keeps the bookkeeping for an eight-slot floating-point register stack. It does not hold the 80-bit values. It holds a 3-bit top pointer, a 16-bit occupancy word with two bits per physical slot, a 16-bit status word and a 16-bit control word. A sequencer sends it one command per cycle. The commands are: reset the state, push, pop, pop twice, move the pointer up, move the pointer down, release a slot, clear exceptions, probe a slot, and load the control word.

The pointer advances modulo eight and is independent of the occupancy bits. Moving the pointer explicitly never touches occupancy, and releasing a slot never moves the pointer.

Every command that addresses an occupied slot or an empty slot is checked before anything is written. A push onto an occupied slot is an overflow. A pop or a probe of an empty slot is an underflow. Either fault raises flags in the status word and leaves the pointer and the occupancy word as they were.

The combinational output `phys_idx` translates a relative reference st(i), given on `cmd_idx`, into a physical slot number. The datapath uses it to address its storage.

Top module: `fpstk_tag_ctrl`

## Requirements
- R1: After reset, and one cycle after an init command (op 1), the outputs read: control word 0x037F, status word 0x0000, occupancy word 0xFFFF, pointer 0.
- R2: A push (op 2) whose target slot (pointer−1 mod 8) holds tag 11 (empty) moves the pointer to that slot and writes tag 00 (valid) into it.
- R3: A push whose target slot is not empty is an overflow. It sets status bit 6 (stack fault), bit 0 (invalid) and bit 9 (C1). The pointer, the occupancy word and all other status bits stay unchanged.
- R4: A pop (op 3) of a non-empty top slot writes tag 11 into that slot and increments the pointer modulo 8.
- R5: A double pop (op 4), when the top slot and the slot above it are both non-empty, empties both slots and advances the pointer by two modulo 8.
- R6: The following are underflows: a pop of an empty top, a double pop with either slot empty, or a probe (op 9) of an empty st(i). An underflow sets status bits 6 and 0, clears bit 9, and leaves the pointer and the occupancy word unchanged. A probe of a non-empty slot changes nothing.
- R7: Increment (op 5) and decrement (op 6) change the pointer by one modulo 8 and clear C1. They leave the occupancy word and the other status bits unchanged.
- R8: Free (op 7) writes tag 11 into the slot of st(cmd_idx) and does not move the pointer.
- R9: `phys_idx` equals (pointer + cmd_idx) mod 8, combinationally from the current pointer.
- R10: Clear-exceptions (op 8) zeroes status bits 7:0 and bit 15 (busy) and keeps bits 14:8.
- R11: Load-control (op 10) copies `cmd_data` into the control word. The status and occupancy words are unchanged.
- R12: Status bits 13:11 always hold the pointer. Occupancy bits 2p+1:2p belong to physical slot p. Opcode 0, opcodes 11 to 15, and any cycle with `cmd_valid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_idx | input | 3 | Relative register number i for st(i) |
| cmd_data | input | 16 | Operand for load-control |
| phys_idx | output | 3 | Physical slot of st(cmd_idx) |
| top_ptr | output | 3 | Current top-of-stack pointer |
| tag_word | output | 16 | Occupancy word, two bits per physical slot |
| status_word | output | 16 | Status word |
| control_word | output | 16 | Control word |

## Verification
`phys_idx` is combinational, so the bench reads it 1 ns after driving a command, before the next clock edge. Pointer, occupancy, status and control are registered and are due right after the first rising edge that follows the command. The driver task queues the expected values on the falling edge where it drives. The monitor removes one entry 2 ns after each rising edge and compares it, so each command is checked in exactly the cycle its result lands.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

  localparam int NREG  = 8;
  localparam int PTR_W = $clog2(NREG);
  localparam int TAG_W = 2 * NREG;
  localparam int WORD_W = 16;

  localparam logic [WORD_W-1:0] CW_RESET = 16'h037F;
  localparam logic [WORD_W-1:0] SW_RESET = 16'h0000;
  localparam logic [TAG_W-1:0]  TW_RESET = {TAG_W{1'b1}};

  localparam logic [1:0] TAG_VALID = 2'b00;
  localparam logic [1:0] TAG_EMPTY = 2'b11;

  localparam int SW_BUSY   = 15;
  localparam int SW_TOP_LO = 11;
  localparam int SW_C1     = 9;
  localparam int SW_EXC_HI = 7;
  localparam int SW_SF     = 6;
  localparam int SW_IE     = 0;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_INIT  = 4'd1,
    OP_PUSH  = 4'd2,
    OP_POP   = 4'd3,
    OP_POP2  = 4'd4,
    OP_INCP  = 4'd5,
    OP_DECP  = 4'd6,
    OP_FREE  = 4'd7,
    OP_CLREX = 4'd8,
    OP_PROBE = 4'd9,
    OP_LDCW  = 4'd10
  } stk_op_e;

  typedef struct packed {
    logic             init;
    logic             ldcw;
    logic             clrex;
    logic             ovf;
    logic             unf;
    logic             c1_clr;
    logic             ptr_we;
    logic [PTR_W-1:0] ptr_nx;
    logic [NREG-1:0]  slot_empty;
    logic [NREG-1:0]  slot_valid;
  } stk_act_t;

endpackage

// File: rtl/fpstk_rst_sync.sv
module fpstk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/fpstk_decode.sv
module fpstk_decode
  import fpstk_pkg::*;
#(
  parameter int N  = NREG,
  parameter int PW = PTR_W
) (
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic [PW-1:0]   cmd_idx,
  input  logic [PW-1:0]   top,
  input  logic [2*N-1:0]  tags,
  output logic [PW-1:0]   phys_idx,
  output stk_act_t        act
);

  logic [PW-1:0] slot_below;
  logic [PW-1:0] slot_above;
  logic [PW-1:0] slot_above2;
  logic [PW-1:0] slot_rel;
  logic          top_empty;
  logic          below_empty;
  logic          above_empty;
  logic          rel_empty;

  function automatic logic slot_is_empty(input logic [2*N-1:0] tw,
                                         input logic [PW-1:0] s);
    return tw[2*s +: 2] == TAG_EMPTY;
  endfunction

  always_comb begin
    slot_below  = top - PW'(1);
    slot_above  = top + PW'(1);
    slot_above2 = top + PW'(2);
    slot_rel    = top + cmd_idx;
    top_empty   = slot_is_empty(tags, top);
    below_empty = slot_is_empty(tags, slot_below);
    above_empty = slot_is_empty(tags, slot_above);
    rel_empty   = slot_is_empty(tags, slot_rel);
  end

  assign phys_idx = slot_rel;

  always_comb begin
    act = '0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_INIT:  act.init = 1'b1;
        OP_PUSH: begin
          if (!below_empty) begin
            act.ovf = 1'b1;
          end else begin
            act.ptr_we                 = 1'b1;
            act.ptr_nx                 = slot_below;
            act.slot_valid[slot_below] = 1'b1;
          end
        end
        OP_POP: begin
          if (top_empty) begin
            act.unf = 1'b1;
          end else begin
            act.ptr_we          = 1'b1;
            act.ptr_nx          = slot_above;
            act.slot_empty[top] = 1'b1;
          end
        end
        OP_POP2: begin
          if (top_empty || above_empty) begin
            act.unf = 1'b1;
          end else begin
            act.ptr_we                 = 1'b1;
            act.ptr_nx                 = slot_above2;
            act.slot_empty[top]        = 1'b1;
            act.slot_empty[slot_above] = 1'b1;
          end
        end
        OP_INCP: begin
          act.ptr_we = 1'b1;
          act.ptr_nx = slot_above;
          act.c1_clr = 1'b1;
        end
        OP_DECP: begin
          act.ptr_we = 1'b1;
          act.ptr_nx = slot_below;
          act.c1_clr = 1'b1;
        end
        OP_FREE:  act.slot_empty[slot_rel] = 1'b1;
        OP_CLREX: act.clrex = 1'b1;
        OP_PROBE: act.unf = rel_empty;
        OP_LDCW:  act.ldcw = 1'b1;
        default:  act = '0;
      endcase
    end
  end

endmodule

// File: rtl/fpstk_tag_file.sv
module fpstk_tag_file
  import fpstk_pkg::*;
#(
  parameter int N = NREG
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init,
  input  logic [N-1:0]   slot_empty,
  input  logic [N-1:0]   slot_valid,
  output logic [2*N-1:0] tags
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [1:0] tag_q;
    logic [1:0] tag_d;
    logic       tag_en;

    always_comb begin
      tag_en = init | slot_empty[g] | slot_valid[g];
      tag_d  = (init | slot_empty[g]) ? TAG_EMPTY : TAG_VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= TAG_EMPTY;
      end else if (tag_en) begin
        tag_q <= tag_d;
      end
    end

    assign tags[2*g +: 2] = tag_q;
  end

endmodule

// File: rtl/fpstk_status_unit.sv
module fpstk_status_unit
  import fpstk_pkg::*;
#(
  parameter int PW = PTR_W,
  parameter int W  = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          ldcw,
  input  logic          clrex,
  input  logic          ovf,
  input  logic          unf,
  input  logic          c1_clr,
  input  logic          ptr_we,
  input  logic [PW-1:0] ptr_nx,
  input  logic [W-1:0]  cmd_data,
  output logic [W-1:0]  sw,
  output logic [W-1:0]  cw
);

  logic [W-1:0] sw_q, sw_d;
  logic [W-1:0] cw_q, cw_d;
  logic         sw_en, cw_en;

  always_comb begin
    sw_en = init | clrex | ovf | unf | c1_clr | ptr_we;
    cw_en = init | ldcw;
    sw_d  = sw_q;
    cw_d  = cw_q;
    if (init) begin
      sw_d = SW_RESET;
      cw_d = CW_RESET;
    end else begin
      if (ldcw) cw_d = cmd_data;
      if (clrex) begin
        sw_d[SW_EXC_HI:0] = '0;
        sw_d[SW_BUSY]     = 1'b0;
      end
      if (ptr_we) sw_d[SW_TOP_LO +: PW] = ptr_nx;
      if (c1_clr) sw_d[SW_C1] = 1'b0;
      if (ovf) begin
        sw_d[SW_SF] = 1'b1;
        sw_d[SW_IE] = 1'b1;
        sw_d[SW_C1] = 1'b1;
      end
      if (unf) begin
        sw_d[SW_SF] = 1'b1;
        sw_d[SW_IE] = 1'b1;
        sw_d[SW_C1] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= SW_RESET;
    end else if (sw_en) begin
      sw_q <= sw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q <= CW_RESET;
    end else if (cw_en) begin
      cw_q <= cw_d;
    end
  end

  assign sw = sw_q;
  assign cw = cw_q;

endmodule

// File: rtl/fpstk_tag_ctrl.sv
module fpstk_tag_ctrl
  import fpstk_pkg::*;
#(
  parameter int N  = NREG,
  parameter int PW = PTR_W,
  parameter int W  = WORD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [3:0]     cmd_op,
  input  logic [PW-1:0]  cmd_idx,
  input  logic [W-1:0]   cmd_data,
  output logic [PW-1:0]  phys_idx,
  output logic [PW-1:0]  top_ptr,
  output logic [2*N-1:0] tag_word,
  output logic [W-1:0]   status_word,
  output logic [W-1:0]   control_word
);

  logic     rst_n_int;
  stk_act_t act;

  fpstk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fpstk_decode #(.N(N), .PW(PW)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .top       (top_ptr),
    .tags      (tag_word),
    .phys_idx  (phys_idx),
    .act       (act)
  );

  fpstk_tag_file #(.N(N)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .init       (act.init),
    .slot_empty (act.slot_empty),
    .slot_valid (act.slot_valid),
    .tags       (tag_word)
  );

  fpstk_status_unit #(.PW(PW), .W(W)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .init     (act.init),
    .ldcw     (act.ldcw),
    .clrex    (act.clrex),
    .ovf      (act.ovf),
    .unf      (act.unf),
    .c1_clr   (act.c1_clr),
    .ptr_we   (act.ptr_we),
    .ptr_nx   (act.ptr_nx),
    .cmd_data (cmd_data),
    .sw       (status_word),
    .cw       (control_word)
  );

  assign top_ptr = status_word[SW_TOP_LO +: PW];

endmodule

// File: rtl/fpstk_tag_ctrl_chk.sv
module fpstk_tag_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [3:0]  cmd_op,
  input logic [2:0]  phys_idx,
  input logic [2:0]  top_ptr,
  input logic [15:0] tag_word,
  input logic [15:0] status_word,
  input logic [15:0] control_word
);

  function automatic logic [1:0] slot_tag(input logic [15:0] tw, input logic [2:0] s);
    return tw[2*s +: 2];
  endfunction

  AST_INIT_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd1 |=> control_word == 16'h037F && status_word == 16'h0000 && tag_word == 16'hFFFF); // R1

  AST_PUSH_OK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd2 && slot_tag(tag_word, top_ptr - 3'd1) == 2'b11
    |=> top_ptr == $past(top_ptr) - 3'd1 && slot_tag(tag_word, top_ptr) == 2'b00); // R2

  AST_NO_OVERFLOW_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd2 && slot_tag(tag_word, top_ptr - 3'd1) != 2'b11
    |=> status_word[6] && status_word[0] && status_word[9] && $stable(tag_word) && $stable(top_ptr)); // R3

  AST_POP_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd3 && slot_tag(tag_word, top_ptr) == 2'b11
    |=> status_word[6] && status_word[0] && !status_word[9] && $stable(tag_word) && $stable(top_ptr)); // R6

  AST_STEP_KEEPS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 4'd5 || cmd_op == 4'd6) |=> $stable(tag_word) && !status_word[9]); // R7

  AST_FREE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd7 |=> $stable(top_ptr) && slot_tag(tag_word, $past(phys_idx)) == 2'b11); // R8

  AST_CLREX_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd8 |=> status_word[7:0] == 8'h00 && !status_word[15] && status_word[14:8] == $past(status_word[14:8])); // R10

endmodule

bind fpstk_tag_ctrl fpstk_tag_ctrl_chk u_chk (.*);

// File: tb/fpstk_tag_ctrl_tb.sv
module fpstk_tag_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [2:0]  cmd_idx;
  logic [15:0] cmd_data;
  logic [2:0]  phys_idx;
  logic [2:0]  top_ptr;
  logic [15:0] tag_word;
  logic [15:0] status_word;
  logic [15:0] control_word;

  always #5 clk = ~clk;

  fpstk_tag_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_idx      (cmd_idx),
    .cmd_data     (cmd_data),
    .phys_idx     (phys_idx),
    .top_ptr      (top_ptr),
    .tag_word     (tag_word),
    .status_word  (status_word),
    .control_word (control_word)
  );

  typedef struct {
    string       req;
    logic [2:0]  top;
    logic [15:0] tag;
    logic [15:0] sts;
    logic [15:0] ctl;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  logic [2:0]  m_top;
  logic [15:0] m_tag;
  logic [15:0] m_sts;
  logic [15:0] m_ctl;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic m_empty(input logic [2:0] s);
    return m_tag[2*s +: 2] == 2'b11;
  endfunction

  task automatic m_underflow();
    m_sts[6] = 1'b1; m_sts[0] = 1'b1; m_sts[9] = 1'b0;
  endtask

  task automatic model(input logic vld, input logic [3:0] op,
                       input logic [2:0] idx, input logic [15:0] data);
    logic [2:0] b, n, t;
    b = m_top - 3'd1; n = m_top + 3'd1; t = m_top + idx;
    if (vld) begin
      case (op)
        4'd1: begin m_ctl = 16'h037F; m_sts = 16'h0000; m_tag = 16'hFFFF; m_top = 3'd0; end
        4'd2: if (!m_empty(b)) begin m_sts[6] = 1'b1; m_sts[0] = 1'b1; m_sts[9] = 1'b1; end
              else begin m_top = b; m_tag[2*b +: 2] = 2'b00; end
        4'd3: if (m_empty(m_top)) m_underflow();
              else begin m_tag[2*m_top +: 2] = 2'b11; m_top = n; end
        4'd4: if (m_empty(m_top) || m_empty(n)) m_underflow();
              else begin m_tag[2*m_top +: 2] = 2'b11; m_tag[2*n +: 2] = 2'b11; m_top = m_top + 3'd2; end
        4'd5: begin m_top = n; m_sts[9] = 1'b0; end
        4'd6: begin m_top = b; m_sts[9] = 1'b0; end
        4'd7: m_tag[2*t +: 2] = 2'b11;
        4'd8: begin m_sts[7:0] = 8'h00; m_sts[15] = 1'b0; end
        4'd9: if (m_empty(t)) m_underflow();
        4'd10: m_ctl = data;
        default: ;
      endcase
    end
    m_sts[13:11] = m_top;
  endtask

  task automatic drive(input string req, input logic vld, input logic [3:0] op,
                       input logic [2:0] idx, input logic [15:0] data);
    exp_t e;
    @(negedge clk);
    cmd_valid = vld; cmd_op = op; cmd_idx = idx; cmd_data = data;
    #1;
    check("R9 phys_idx", {29'd0, phys_idx}, {29'd0, m_top + idx});
    model(vld, op, idx, data);
    e.req = req; e.top = m_top; e.tag = m_tag; e.sts = m_sts; e.ctl = m_ctl;
    exp_q.push_back(e);
  endtask

  // Monitor: registered results are due just after the next rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check({e.req, " top (R12)"}, {29'd0, top_ptr}, {29'd0, e.top});
      check({e.req, " tags"},      {16'd0, tag_word}, {16'd0, e.tag});
      check({e.req, " status"},    {16'd0, status_word}, {16'd0, e.sts});
      check({e.req, " control"},   {16'd0, control_word}, {16'd0, e.ctl});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 4'd0; cmd_idx = 3'd0; cmd_data = 16'd0;
    m_top = 3'd0; m_tag = 16'hFFFF; m_sts = 16'h0000; m_ctl = 16'h037F;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    check("R1 reset control", {16'd0, control_word}, 32'h037F);
    check("R1 reset status",  {16'd0, status_word},  32'h0000);
    check("R1 reset tags",    {16'd0, tag_word},     32'hFFFF);
    check("R1 reset top",     {29'd0, top_ptr},      32'd0);

    // R2 fill the stack, R3 overflow on the ninth push
    for (int k = 0; k < 8; k++) drive("R2 push", 1'b1, 4'd2, 3'd0, 16'd0);
    drive("R3 overflow push", 1'b1, 4'd2, 3'd0, 16'd0);
    drive("R9 probe full", 1'b1, 4'd9, 3'd5, 16'd0);
    drive("R10 clear exceptions", 1'b1, 4'd8, 3'd0, 16'd0);
    // R4 / R5
    drive("R4 pop", 1'b1, 4'd3, 3'd0, 16'd0);
    drive("R5 double pop", 1'b1, 4'd4, 3'd0, 16'd0);
    // R8 free then R6 probe of freed slot
    drive("R8 free st2", 1'b1, 4'd7, 3'd2, 16'd0);
    drive("R6 probe empty", 1'b1, 4'd9, 3'd2, 16'd0);
    drive("R6 probe valid", 1'b1, 4'd9, 3'd1, 16'd0);
    drive("R10 clear again", 1'b1, 4'd8, 3'd0, 16'd0);
    // R7 pointer stepping with wrap
    for (int k = 0; k < 9; k++) drive("R7 increment", 1'b1, 4'd5, 3'd0, 16'd0);
    for (int k = 0; k < 10; k++) drive("R7 decrement", 1'b1, 4'd6, 3'd0, 16'd0);
    // R12 ignored commands
    drive("R12 valid low push", 1'b0, 4'd2, 3'd0, 16'd0);
    drive("R12 nop", 1'b1, 4'd0, 3'd0, 16'd0);
    for (int k = 11; k < 16; k++) drive("R12 unused opcode", 1'b1, 4'(k), 3'd3, 16'hFFFF);
    // R11 control load
    drive("R11 load control", 1'b1, 4'd10, 3'd0, 16'h1A5C);
    // R6 drain until underflow
    drive("R1 init", 1'b1, 4'd1, 3'd0, 16'd0);
    drive("R2 push one", 1'b1, 4'd2, 3'd0, 16'd0);
    drive("R6 double pop one valid", 1'b1, 4'd4, 3'd0, 16'd0);
    drive("R4 pop last", 1'b1, 4'd3, 3'd0, 16'd0);
    drive("R6 pop empty", 1'b1, 4'd3, 3'd0, 16'd0);
    drive("R6 double pop empty", 1'b1, 4'd4, 3'd0, 16'd0);
    // R3 overflow after pointer moved onto an occupied slot
    drive("R2 push", 1'b1, 4'd2, 3'd0, 16'd0);
    drive("R7 increment", 1'b1, 4'd5, 3'd0, 16'd0);
    drive("R3 overflow on occupied", 1'b1, 4'd2, 3'd0, 16'd0);
    drive("R8 free st7", 1'b1, 4'd7, 3'd7, 16'd0);
    drive("R1 init end", 1'b1, 4'd1, 3'd0, 16'd0);
    @(negedge clk) cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule